// File: doc/BRIEF.md
# I2C Port Expander Register File

This block is an I2C target that gives a host eight general-purpose port pins. The host reaches them through four byte-wide registers: a sensed-level register, a driven-value register, a per-bit polarity inversion mask and a per-bit direction mask. SCL and SDA are sampled with the system clock through synchronizers. START and STOP are recognised as SDA edges while SCL is high.

A write transfer carries the target address, a command byte that sets the register pointer, and then data bytes for the selected register. A read transfer returns the register named by the last command byte, one byte per acknowledged slot. Each pin has its own output enable: the pin is driven from the driven-value register when its direction bit is 0, and is left floating when the bit is 1.

Top module: `i2c_port_expander`

## Requirements
- R1: While `rst` is high, and right after it falls, the driven-value register is 0x00, the polarity mask is 0x00 and the direction mask is 0xFF. So `pin_o` = 0x00, `pin_oe` = 0x00, `sda_oe` = 0 and the bus engine is idle.
- R2: The block acknowledges only the 7-bit address `TGT_ADDR` (default 0x20), sent MSB first with the R/W bit last (0 = write). A transfer to any other address gets no acknowledge and changes no register until the next START.
- R3: In a write transfer, the first byte after the address is a command that sets the register pointer: 0 = sensed level, 1 = driven value, 2 = polarity mask, 3 = direction mask. The pointer is kept for a later read that follows a repeated START.
- R4: A data byte written with pointer 0 is acknowledged and has no effect on any register or pin.
- R5: `pin_o` equals the driven-value register, and `pin_oe[i]` is the inverse of direction bit i (1 = input, output disabled). Pins change only in response to a completed data byte.
- R6: A read with pointer 1 returns the stored driven value, not the level seen on `pin_i`.
- R7: A read with pointer 0 returns the synchronized `pin_i` XOR the polarity mask, for every pin whatever its direction.
- R8: Pointer values above 3 are acknowledged. Data written to them is dropped, and reads from them return 0x00.
- R9: The sensed byte is captured on the falling SCL edge at which its first (MSB) bit is driven. Pin changes during the byte do not alter it, and the next acknowledged byte carries the new level.
- R10: Further write bytes go to the same register, so the last byte wins. Further reads repeat the same register while the host acknowledges, and a host NACK ends the read. A STOP or a repeated START at any point returns the engine to idle or to the address phase, and a partial byte writes nothing.
- R11: `sda_oe` (1 = pull SDA low) changes only after a falling SCL edge, a START or a STOP, and never rises while SCL is high. Read data goes out MSB first with a 1 bit leaving SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| pin_i | input | 8 | Level present on each port pin |
| pin_o | output | 8 | Driven value for each port pin |
| pin_oe | output | 8 | Per-pin output enable, 1 = drive |

## Verification
The hardest case to bring about is a change on the pins while a sensed byte is being shifted out. The change has to land after the capturing SCL fall and before the next acknowledge. The bench does this with a read task that changes the external pin values after a chosen bit. It expects the old value in that byte and the new one in the next acknowledged byte. A STOP sent in the middle of a data byte, a wrong address followed by data, and writes to unused pointers are also driven on purpose. These sit alongside seeded random mixes of reads, writes, pin values and pointers.

// File: rtl/exp_pkg.sv
package exp_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CMD_SENSE  = 8'd0;
    localparam byte_t CMD_DRIVE  = 8'd1;
    localparam byte_t CMD_INVERT = 8'd2;
    localparam byte_t CMD_DIR    = 8'd3;

    localparam byte_t DRIVE_RST  = '0;
    localparam byte_t INVERT_RST = '0;
    localparam byte_t DIR_RST    = '1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic  en;
        byte_t ptr;
        byte_t data;
    } reg_wr_t;

    function automatic byte_t reg_read(byte_t ptr, byte_t level, byte_t drive,
                                       byte_t invert, byte_t dir);
        case (ptr)
            CMD_SENSE:  return level ^ invert;
            CMD_DRIVE:  return drive;
            CMD_INVERT: return invert;
            CMD_DIR:    return dir;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/exp_sync.sv
module exp_sync #(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_lvl,
    output exp_pkg::bus_ev_t ev
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q    <= '1;
            sda_q    <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_q    <= {scl_q[STAGES-2:0], scl_i};
            sda_q    <= {sda_q[STAGES-2:0], sda_i};
            scl_prev <= scl_q[STAGES-1];
            sda_prev <= sda_q[STAGES-1];
        end
    end

    assign scl_now = scl_q[STAGES-1];
    assign sda_now = sda_q[STAGES-1];

    always_comb begin
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
        ev.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
        ev.sda      = sda_now;
    end

    assign scl_lvl = scl_now;

endmodule

// File: rtl/exp_bus_fsm.sv
module exp_bus_fsm
    import exp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TGT_ADDR = 7'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  byte_t      rd_byte,
    output logic       sda_oe,
    output reg_wr_t    wr,
    output byte_t      ptr,
    output bus_state_e state
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0] cnt;
    byte_t            sh;
    byte_t            tx;
    logic             rnw;
    logic             mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            rnw    <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
            ptr    <= '0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (ev.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == CNT_FULL) begin
                            cnt <= '0;
                            case (state)
                                ST_ADDR: begin
                                    if (sh[BYTE_W-1:1] == TGT_ADDR) begin
                                        rnw    <= sh[0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_ADDR_ACK;
                                    end else begin
                                        state  <= ST_IDLE;
                                    end
                                end
                                ST_CMD: begin
                                    ptr    <= sh;
                                    sda_oe <= 1'b1;
                                    state  <= ST_CMD_ACK;
                                end
                                default: begin
                                    wr.en   <= 1'b1;
                                    wr.ptr  <= ptr;
                                    wr.data <= sh;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_WDATA_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rnw) begin
                                tx     <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_CMD;
                            end
                        end
                    end
                    ST_CMD_ACK, ST_WDATA_ACK: begin
                        if (ev.scl_fall) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            cnt <= '0;
                            if (mack) begin
                                tx     <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/exp_regs.sv
module exp_regs
    import exp_pkg::*;
#(
    parameter int PIN_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  byte_t   pin_i,
    input  reg_wr_t wr,
    input  byte_t   ptr,
    output byte_t   rd_byte,
    output byte_t   drive_q,
    output byte_t   dir_q
);
    byte_t pin_q [PIN_STAGES];
    byte_t invert_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < PIN_STAGES; s++) pin_q[s] <= '0;
        end else begin
            pin_q[0] <= pin_i;
            for (int s = 1; s < PIN_STAGES; s++) pin_q[s] <= pin_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q  <= DRIVE_RST;
            invert_q <= INVERT_RST;
            dir_q    <= DIR_RST;
        end else if (wr.en) begin
            case (wr.ptr)
                CMD_DRIVE:  drive_q  <= wr.data;
                CMD_INVERT: invert_q <= wr.data;
                CMD_DIR:    dir_q    <= wr.data;
                default:    ;
            endcase
        end
    end

    assign rd_byte = reg_read(ptr, pin_q[PIN_STAGES-1], drive_q, invert_q, dir_q);

endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
    import exp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TGT_ADDR    = 7'h20,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] pin_i,
    output logic [BYTE_W-1:0] pin_o,
    output logic [BYTE_W-1:0] pin_oe
);
    bus_ev_t    ev;
    reg_wr_t    wr;
    byte_t      ptr;
    byte_t      rd_byte;
    byte_t      drive_q;
    byte_t      dir_q;
    bus_state_e state;
    logic       scl_sync;
    logic       scl_fall_w;
    logic       start_w;
    logic       stop_w;
    logic       wr_en_w;

    exp_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_sync),
        .ev      (ev)
    );

    exp_bus_fsm #(.TGT_ADDR(TGT_ADDR)) fsm_i (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_byte (rd_byte),
        .sda_oe  (sda_oe),
        .wr      (wr),
        .ptr     (ptr),
        .state   (state)
    );

    exp_regs #(.PIN_STAGES(SYNC_STAGES)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pin_i),
        .wr      (wr),
        .ptr     (ptr),
        .rd_byte (rd_byte),
        .drive_q (drive_q),
        .dir_q   (dir_q)
    );

    for (genvar g = 0; g < BYTE_W; g++) begin : g_pin
        assign pin_o[g]  = drive_q[g];
        assign pin_oe[g] = ~dir_q[g];
    end

    assign scl_fall_w = ev.scl_fall;
    assign start_w    = ev.start;
    assign stop_w     = ev.stop;
    assign wr_en_w    = wr.en;

endmodule

// File: rtl/exp_checker.sv
module exp_checker
    import exp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              scl_fall,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              wr_en,
    input bus_state_e        state,
    input logic [BYTE_W-1:0] pin_o,
    input logic [BYTE_W-1:0] pin_oe
);

    assert_reset_defaults_R1: assert property (@(posedge clk)
        rst |=> (pin_o == '0 && pin_oe == '0 && !sda_oe));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    assert_pins_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(pin_o) && $stable(pin_oe)));

    assert_sda_on_event_R11: assert property (@(posedge clk) disable iff (rst)
        (!scl_fall && !bus_start && !bus_stop) |=> $stable(sda_oe));

    assert_sda_rise_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

endmodule

bind i2c_port_expander exp_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .scl_s     (scl_sync),
    .scl_fall  (scl_fall_w),
    .bus_start (start_w),
    .bus_stop  (stop_w),
    .wr_en     (wr_en_w),
    .state     (state),
    .pin_o     (pin_o),
    .pin_oe    (pin_oe)
);

// File: tb/i2c_port_expander_tb.sv
module i2c_port_expander_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int MAX_CYC    = 190000;
    localparam logic [6:0] ADDR = 7'h20;

    logic       clk = 1'b0;
    logic       rst;
    logic       scl_m, sda_m;
    logic       sda_oe;
    logic [7:0] ext;
    logic [7:0] pin_i, pin_o, pin_oe;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] m_drive, m_inv, m_dir;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pin_i = (pin_oe & pin_o) | (~pin_oe & ext);

    i2c_port_expander dut_i (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .pin_i  (pin_i),
        .pin_o  (pin_o),
        .pin_oe (pin_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] cmd);
        logic [7:0] lvl;
        lvl = (~m_dir & m_drive) | (m_dir & ext);
        case (cmd)
            8'd0: return lvl ^ m_inv;
            8'd1: return m_drive;
            8'd2: return m_inv;
            8'd3: return m_dir;
            default: return 8'h00;
        endcase
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = ~sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic mack, input int chg_bit, input logic [7:0] chg_val,
                             output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq();
            scl_m = 1'b1; wq();
            b[7-i] = sda_line; wq();
            scl_m = 1'b0;
            if (i == chg_bit) ext = chg_val;
            wq();
        end
        sda_m = ~mack; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                          output logic [2:0] acks);
        i2c_start();
        send_byte({a, 1'b0}, acks[2]);
        send_byte(cmd, acks[1]);
        send_byte(d, acks[0]);
        i2c_stop();
    endtask

    task automatic rd_txn(input logic [7:0] cmd, output logic [7:0] d, output logic [2:0] acks);
        i2c_start();
        send_byte({ADDR, 1'b0}, acks[2]);
        send_byte(cmd, acks[1]);
        i2c_start();
        send_byte({ADDR, 1'b1}, acks[0]);
        recv_byte(1'b0, -1, 8'h00, d);
        i2c_stop();
    endtask

    task automatic do_write(input string tag, input logic [7:0] cmd, input logic [7:0] d);
        logic [2:0] acks;
        wr_txn(ADDR, cmd, d, acks);
        chk({tag, " acks"}, {5'd0, acks}, 8'h07);
        case (cmd)
            8'd1: m_drive = d;
            8'd2: m_inv   = d;
            8'd3: m_dir   = d;
            default: ;
        endcase
    endtask

    task automatic do_read(input string tag, input logic [7:0] cmd);
        logic [2:0] acks;
        logic [7:0] d;
        rd_txn(cmd, d, acks);
        chk({tag, " acks"}, {5'd0, acks}, 8'h07);
        chk(tag, d, exp_read(cmd));
    endtask

    task automatic chk_pins(input string tag);
        repeat (4) @(negedge clk);
        chk({tag, " pin_o"}, pin_o, m_drive);
        chk({tag, " pin_oe"}, pin_oe, ~m_dir);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] d0, d1;
        logic       a;
        void'($urandom(32'h1234abcd));
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; ext = 8'h00;
        m_drive = 8'h00; m_inv = 8'h00; m_dir = 8'hFF;
        repeat (5) @(negedge clk);
        chk("R1 in reset pin_oe", pin_oe, 8'h00);
        chk("R1 in reset sda_oe", {7'd0, sda_oe}, 8'h00);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk_pins("R1 after reset");
        do_read("R1 R3 dir reset", 8'd3);
        do_read("R1 R3 invert reset", 8'd2);
        do_read("R1 R3 drive reset", 8'd1);

        // R5 directions and driven values
        do_write("R5 drive", 8'd1, 8'hA5);
        do_write("R5 dir", 8'd3, 8'h0F);
        chk_pins("R5");
        ext = 8'h3C;
        do_read("R7 sense mixed dir", 8'd0);
        chk("R7 sense value", exp_read(8'd0), 8'hAC);
        do_read("R6 drive not pin", 8'd1);
        do_write("R7 invert", 8'd2, 8'hFF);
        do_read("R7 sense inverted", 8'd0);

        // R4 write to sensed register ignored
        do_write("R4 write sense", 8'd0, 8'h77);
        chk_pins("R4");
        do_read("R4 sense unchanged", 8'd0);

        // R8 unused pointers
        do_write("R8 write ptr5", 8'd5, 8'h99);
        chk_pins("R8");
        do_read("R8 read ptr5", 8'd5);
        do_read("R8 read ptrFF", 8'hFF);

        // R2 wrong address
        wr_txn(7'h21, 8'd1, 8'h5A, acks);
        chk("R2 wrong addr ack", {7'd0, acks[2]}, 8'h00);
        chk_pins("R2 wrong addr");

        // R10 multi-byte write, last wins
        i2c_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'd1, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        chk("R10 multi write ack", {7'd0, a}, 8'h01);
        i2c_stop();
        m_drive = 8'h33;
        chk_pins("R10 multi write");

        // R10 stop inside a data byte writes nothing
        i2c_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'd1, a);
        send_bits(8'hF0, 4);
        i2c_stop();
        chk_pins("R10 partial byte");

        // R9 capture point and R10 repeated reads
        do_write("R9 dir", 8'd3, 8'hFF);
        do_write("R9 invert", 8'd2, 8'h00);
        ext = 8'hF0;
        repeat (10) @(negedge clk);
        i2c_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'd0, a);
        i2c_start();
        send_byte({ADDR, 1'b1}, a);
        recv_byte(1'b1, 0, 8'h0F, d0);
        recv_byte(1'b0, -1, 8'h00, d1);
        i2c_stop();
        chk("R9 captured byte stable", d0, 8'hF0);
        chk("R9 R10 next byte new level", d1, 8'h0F);
        do_read("R11 after NACK", 8'd3);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            logic [7:0] cmd, dat;
            cmd = 8'($urandom_range(0, 5));
            dat = 8'($urandom);
            ext = 8'($urandom);
            if ($urandom_range(0, 1) == 1) begin
                do_write("R3 R5 random write", cmd, dat);
                chk_pins("R5 random");
            end else begin
                do_read("R3 R7 R11 random read", cmd);
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule